// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that a host sets up by writing an 8-bit control word to a shared control port. The host then loads a starting count, one or two bytes at a time, through the channel's data port. Several channels can share the control port, and each one acts only on words whose select field carries its own channel number. The counter steps on a one-cycle tick pulse taken from a slow external clock. A gate input can pause counting. The channel produces a single waveform output whose shape depends on the programmed mode.

The control word chooses the counting base, the byte order for loads and reads, and one of three waveforms. In terminal-count mode the output goes high once, when the count runs out. In rate mode the output gives one low tick per period. In square mode the output spends half of each period high and half low. The count can be read back at any time through the data port. A latch command freezes a snapshot of the count so that both bytes of the read describe the same instant, while the counter keeps running.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset the output is low, the counter holds 0, and data-port reads use LSB-then-MSB order, so the two reads return 0x00 and 0x00.
- R2: The control word is laid out as select[7:6], access[5:4], mode[3:1], bcd[0]. A word whose select field differs from the CHAN_ID parameter, including select 2'b11, leaves the channel unchanged.
- R3: A word for this channel with a non-latch access field and a mode field of 3'b001, 3'b100 or 3'b101 is ignored as a whole.
- R4: The access field sets the byte order for loads and for reads. 2'b01 moves only the low byte, and the high byte of a load is zero. 2'b10 moves only the high byte, and the low byte of a load is zero. 2'b11 moves the low byte first and the high byte second.
- R5: A completed load does not change the counter until the next tick. That tick copies the load value into the counter without decrementing it.
- R6: Mode 3'b000: the output goes low when the control word or a completed load is accepted. It goes high on the tick that brings the counter to zero, which is N ticks after the load tick. It then stays high until the next control word or load.
- R7: While the gate is low, ticks do not change the count. In modes 2 and 3 the output is also held high while the gate is low.
- R8: Mode x10: the count runs N down to 1 and then reloads to N. The output is low only while the count is 1, giving one low tick every N ticks.
- R9: Mode x11: the count runs N down to 1 and then reloads to N. The output is high for (N+1)/2 ticks and low for N/2 ticks (integer division) of each period.
- R10: bcd=1 counts in four decimal digits. 0x0010 steps to 0x0009, and square-mode halving uses the decimal value.
- R11: A load value of zero stands for 65536 in binary and 10000 in decimal, so the first decrement gives 0xFFFF or 0x9999.
- R12: Access field 2'b00 latches the count. Reads return the frozen value until every byte of the current access order has been read, even while counting continues. A second latch before then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | One-cycle count enable from the slow clock |
| gate | input | 1 | Counting permitted when high |
| wr_en | input | 1 | Write strobe for either port |
| wr_ctrl | input | 1 | 1 selects the control port, 0 the data port |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Data-port read strobe; advances the read byte order |
| rd_data | output | 8 | Byte currently presented by the data port |
| out_pin | output | 1 | Channel waveform output |

## Verification
A wrong count or reload value shows up at the output within one period: the low pulse or the half-period boundary moves by a tick. It also shows in the bytes read back right after the next tick. A stuck byte pointer swaps low and high bytes on the very next read. A latch that is released too early returns a moving value on the second byte. A bad decimal decrement produces a byte that is not valid decimal on the first tick that borrows across a digit. Mis-decoded control words show up on the output at the next clock edge, for example as a terminal-count output that drops when it should not.

// File: rtl/icc_pkg.sv
// Shared widths, field encodings and count arithmetic for the interval counter channel.
package icc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LOW   = 2'b01,
        ACC_HIGH  = 2'b10,
        ACC_PAIR  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        MD_TERM   = 2'd0,
        MD_RATE   = 2'd1,
        MD_SQUARE = 2'd2
    } mode_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    // True for the mode encodings this channel implements.
    function automatic logic mode_supported(input logic [2:0] m);
        return (m == 3'b000) || (m[1:0] == 2'b10) || (m[1:0] == 2'b11);
    endfunction

    // Map a supported mode field to the internal mode.
    function automatic mode_e mode_map(input logic [2:0] m);
        if (m == 3'b000)       return MD_TERM;
        else if (m[1:0] == 2'b10) return MD_RATE;
        else                   return MD_SQUARE;
    endfunction

    // Decrement by one in binary or in decimal digits; zero wraps to the maximum.
    function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        if (!bcd) return v - CNT_W'(1);
        r      = v;
        borrow = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                if (v[4*i +: 4] == 4'd0) begin
                    r[4*i +: 4] = 4'd9;
                end else begin
                    r[4*i +: 4] = v[4*i +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Half of a load value (rounded down); zero stands for the full range.
    function automatic logic [CNT_W-1:0] count_half(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic             odd_up;
        if (v == '0) return bcd ? (CNT_W'(5) << (CNT_W - 4)) : (CNT_W'(1) << (CNT_W - 1));
        if (!bcd) return v >> 1;
        r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            odd_up      = (i < DIGITS - 1) ? v[(4*i + 4) % CNT_W] : 1'b0;
            r[4*i +: 4] = {1'b0, v[4*i + 1 +: 3]} + (odd_up ? 4'd5 : 4'd0);
        end
        return r;
    endfunction
endpackage

// File: rtl/icc_cfg.sv
// Control-word decode and load-byte sequencing for one channel.
// Assumes at most one write per clock; the control word and a data byte never arrive together.
// cfg_new, latch_req and load_done are combinational so the state they trigger lands on the write edge.
module icc_cfg import icc_pkg::*; #(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output acc_e              acc_q,
    output mode_e             mode_q,
    output logic              bcd_q,
    output logic              cfg_new,
    output logic              latch_req,
    output logic              load_done,
    output logic [CNT_W-1:0]  load_val
);
    ctrl_word_t        cw;
    logic              sel_hit;
    logic              data_wr;
    logic              wr_hi_q;
    logic [BYTE_W-1:0] low_hold_q;

    assign cw        = ctrl_word_t'(wr_data);
    assign sel_hit   = wr_en && wr_ctrl && (cw.sel != 2'b11) && (cw.sel == 2'(CHAN_ID));
    assign latch_req = sel_hit && (cw.acc == ACC_LATCH);
    assign cfg_new   = sel_hit && (cw.acc != ACC_LATCH) && mode_supported(cw.mode);
    assign data_wr   = wr_en && !wr_ctrl;
    assign load_done = data_wr && ((acc_q != ACC_PAIR) || wr_hi_q);

    // Assemble the load value from the byte order in force.
    always_comb begin
        case (acc_q)
            ACC_LOW:  load_val = {{BYTE_W{1'b0}}, wr_data};
            ACC_HIGH: load_val = {wr_data, {BYTE_W{1'b0}}};
            default:  load_val = {wr_data, low_hold_q};
        endcase
    end

    // Hold the channel setup and the pending low byte of a two-byte load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_PAIR;
            mode_q     <= MD_TERM;
            bcd_q      <= 1'b0;
            wr_hi_q    <= 1'b0;
            low_hold_q <= '0;
        end else if (cfg_new) begin
            acc_q   <= cw.acc;
            mode_q  <= mode_map(cw.mode);
            bcd_q   <= cw.bcd;
            wr_hi_q <= 1'b0;
        end else if (data_wr && (acc_q == ACC_PAIR)) begin
            if (!wr_hi_q) low_hold_q <= wr_data;
            wr_hi_q <= !wr_hi_q;
        end
    end
endmodule

// File: rtl/icc_core.sv
// Down-counter, reload and waveform generation for one channel.
// Assumes tick is a single-cycle pulse; a completed load is taken on the next tick.
module icc_core import icc_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  mode_e            mode_i,
    input  logic             bcd_i,
    input  logic             cfg_new,
    input  logic             load_done,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic             armed_q,
    output logic             pend_q,
    output logic             out_o
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] pend_val_q;
    logic [CNT_W-1:0] nxt_dec;
    logic             tc_q;
    logic             at_one;

    assign nxt_dec = count_dec(count_q, bcd_i);
    assign at_one  = (count_q == CNT_W'(1));

    // Count, reload and track terminal count for the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= '0;
            reload_q   <= '0;
            half_q     <= '0;
            pend_val_q <= '0;
            pend_q     <= 1'b0;
            armed_q    <= 1'b0;
            tc_q       <= 1'b0;
        end else if (cfg_new) begin
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
            tc_q    <= 1'b0;
        end else begin
            if (tick) begin
                if (pend_q) begin
                    count_q  <= pend_val_q;
                    reload_q <= pend_val_q;
                    half_q   <= count_half(pend_val_q, bcd_i);
                    armed_q  <= 1'b1;
                    pend_q   <= 1'b0;
                end else if (armed_q && gate) begin
                    if (mode_i == MD_TERM) begin
                        count_q <= nxt_dec;
                        if (nxt_dec == '0) tc_q <= 1'b1;
                    end else begin
                        count_q <= at_one ? reload_q : nxt_dec;
                    end
                end
            end
            if (load_done) begin
                pend_q     <= 1'b1;
                pend_val_q <= load_val;
                tc_q       <= 1'b0;
            end
        end
    end

    // Shape the output from the mode and the counter state.
    always_comb begin
        case (mode_i)
            MD_RATE:   out_o = !armed_q || !gate || !at_one;
            MD_SQUARE: out_o = !armed_q || !gate || (count_q == '0) || (count_q > half_q);
            default:   out_o = tc_q;
        endcase
    end
endmodule

// File: rtl/icc_readout.sv
// Data-port read sequencing and the count latch.
// Assumes the read byte order only changes together with a new control word (cfg_new).
module icc_readout import icc_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc_i,
    input  logic              cfg_new,
    input  logic              latch_req,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  count_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic              latched_q
);
    logic [CNT_W-1:0] latch_val_q;
    logic [CNT_W-1:0] src;
    logic             rd_hi_q;
    logic             last_byte;

    assign src       = latched_q ? latch_val_q : count_i;
    assign last_byte = (acc_i != ACC_PAIR) || rd_hi_q;

    // Present the byte selected by the read order.
    always_comb begin
        case (acc_i)
            ACC_HIGH: rd_data = src[CNT_W-1:BYTE_W];
            ACC_PAIR: rd_data = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            default:  rd_data = src[BYTE_W-1:0];
        endcase
    end

    // Capture the snapshot and step through the read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q   <= 1'b0;
            latch_val_q <= '0;
            rd_hi_q     <= 1'b0;
        end else if (cfg_new) begin
            latched_q <= 1'b0;
            rd_hi_q   <= 1'b0;
        end else begin
            if (latch_req && !latched_q) begin
                latched_q   <= 1'b1;
                latch_val_q <= count_i;
            end
            if (rd_en) begin
                if (acc_i == ACC_PAIR) rd_hi_q <= !rd_hi_q;
                if (latched_q && last_byte) latched_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/interval_counter_channel.sv
// One programmable interval counter channel: control decode, counter and read path.
// Assumes the host serialises port accesses and cnt_tick is already synchronous to clk.
module interval_counter_channel import icc_pkg::*; #(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              gate,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              out_pin
);
    acc_e             cfg_acc;
    mode_e            cfg_mode;
    logic             cfg_bcd;
    logic             cfg_new;
    logic             latch_req;
    logic             load_done;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] core_count;
    logic             core_armed;
    logic             core_pend;
    logic             rd_latched;

    icc_cfg #(.CHAN_ID(CHAN_ID)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .acc_q     (cfg_acc),
        .mode_q    (cfg_mode),
        .bcd_q     (cfg_bcd),
        .cfg_new   (cfg_new),
        .latch_req (latch_req),
        .load_done (load_done),
        .load_val  (load_val)
    );

    icc_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .gate      (gate),
        .mode_i    (cfg_mode),
        .bcd_i     (cfg_bcd),
        .cfg_new   (cfg_new),
        .load_done (load_done),
        .load_val  (load_val),
        .count_q   (core_count),
        .armed_q   (core_armed),
        .pend_q    (core_pend),
        .out_o     (out_pin)
    );

    icc_readout u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (cfg_acc),
        .cfg_new   (cfg_new),
        .latch_req (latch_req),
        .rd_en     (rd_en),
        .count_i   (core_count),
        .rd_data   (rd_data),
        .latched_q (rd_latched)
    );
endmodule

// File: rtl/icc_checker.sv
// Temporal checks for the interval counter channel, bound onto every instance.
module icc_checker import icc_pkg::*; #(
    parameter int CHAN_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_tick,
    input logic              gate,
    input logic              wr_en,
    input logic              wr_ctrl,
    input logic [BYTE_W-1:0] wr_data,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              out_pin,
    input acc_e              cfg_acc,
    input mode_e             cfg_mode,
    input logic              cfg_bcd,
    input logic [CNT_W-1:0]  core_count,
    input logic              core_armed,
    input logic              core_pend,
    input logic              rd_latched
);
    // R2: words for another channel or select 2'b11 leave the setup alone
    a_r2_foreign_word: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctrl && wr_data[7:6] != 2'(CHAN_ID)) |=> $stable({cfg_acc, cfg_mode, cfg_bcd}));

    // R6: an accepted terminal-count setup drives the output low
    a_r6_setup_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ctrl && wr_data[7:6] == 2'(CHAN_ID) && wr_data[5:4] != 2'b00 && wr_data[3:1] == 3'b000)
        |=> !out_pin);

    // R6: once high in terminal-count mode the output holds until a write
    a_r6_sticky_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MD_TERM && out_pin && !wr_en) |=> out_pin);

    // R7: a tick with the gate low leaves the count unchanged
    a_r7_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !gate && core_armed && !core_pend && !wr_en) |=> $stable(core_count));

    // R8: the rate-mode low phase ends at the next tick
    a_r8_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MD_RATE && !out_pin && cnt_tick && !core_pend && !wr_en) |=> out_pin);

    // R12: a held snapshot does not move until read or rewritten
    a_r12_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latched && !rd_en && !wr_en) |=> $stable(rd_data));
endmodule

bind interval_counter_channel icc_checker #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .gate       (gate),
    .wr_en      (wr_en),
    .wr_ctrl    (wr_ctrl),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .out_pin    (out_pin),
    .cfg_acc    (cfg_acc),
    .cfg_mode   (cfg_mode),
    .cfg_bcd    (cfg_bcd),
    .core_count (core_count),
    .core_armed (core_armed),
    .core_pend  (core_pend),
    .rd_latched (rd_latched)
);

// File: tb/interval_counter_channel_tb.sv
// Directed bench: one task per scenario; the DUT answers to channel 1.
module interval_counter_channel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       gate = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       out_pin;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    interval_counter_channel #(.CHAN_ID(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
        .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .out_pin(out_pin)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic is_ctrl, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = is_ctrl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic tick1;
        @(negedge clk); cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] v);
        @(negedge clk); #1;
        v = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_pair(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd_byte(lo); rd_byte(hi);
        v = {hi, lo};
    endtask

    task automatic out_is(input string tag, input logic exp);
        #1; chk(tag, {15'd0, out_pin}, {15'd0, exp});
    endtask

    task automatic t_reset;
        logic [15:0] v;
        out_is("R1 output after reset", 1'b0);
        rd_pair(v);
        chk("R1 count after reset", v, 16'h0000);
    endtask

    task automatic t_term;
        logic [15:0] v;
        put(1, 8'h70);
        out_is("R6 low after setup", 1'b0);
        put(0, 8'h03); put(0, 8'h00);
        rd_pair(v);
        chk("R5 no load before tick", v, 16'h0000);
        tick1;
        rd_pair(v);
        chk("R5 R4 load tick copies value", v, 16'h0003);
        tick1; tick1;
        out_is("R6 low before terminal count", 1'b0);
        tick1;
        out_is("R6 high at terminal count", 1'b1);
        tick1; tick1;
        out_is("R6 stays high", 1'b1);
    endtask

    task automatic t_select;
        put(1, 8'h30);
        out_is("R2 other channel ignored", 1'b1);
        put(1, 8'hF0);
        out_is("R2 select 11 ignored", 1'b1);
        put(1, 8'h72);
        out_is("R3 mode 001 ignored", 1'b1);
        put(1, 8'h78);
        out_is("R3 mode 100 ignored", 1'b1);
        put(1, 8'h70);
        out_is("R2 own channel accepted", 1'b0);
    endtask

    task automatic t_order;
        logic [7:0] b;
        put(1, 8'h50); put(0, 8'h05); tick1;
        rd_byte(b); chk("R4 low-only read", {8'h00, b}, 16'h0005);
        rd_byte(b); chk("R4 low-only read repeats", {8'h00, b}, 16'h0005);
        put(1, 8'h60); put(0, 8'h02); tick1;
        rd_byte(b); chk("R4 high-only load", {8'h00, b}, 16'h0002);
        tick1;
        rd_byte(b); chk("R4 high-only after decrement", {8'h00, b}, 16'h0001);
    endtask

    task automatic t_gate;
        logic [15:0] v;
        put(1, 8'h70); put(0, 8'h05); put(0, 8'h00); tick1;
        gate = 1'b0;
        tick1; tick1; tick1;
        rd_pair(v); chk("R7 gate low freezes count", v, 16'h0005);
        gate = 1'b1;
        tick1;
        rd_pair(v); chk("R7 gate high resumes", v, 16'h0004);
        put(1, 8'h74); put(0, 8'h02); put(0, 8'h00); tick1; tick1;
        out_is("R8 low at count one", 1'b0);
        gate = 1'b0;
        out_is("R7 gate low forces high", 1'b1);
        gate = 1'b1;
        out_is("R7 gate release", 1'b0);
        tick1;
    endtask

    task automatic t_rate;
        put(1, 8'h74); put(0, 8'h04); put(0, 8'h00); tick1;
        out_is("R8 high after load", 1'b1);
        for (int k = 1; k <= 8; k++) begin
            tick1;
            out_is($sformatf("R8 rate tick %0d", k), (4 - (k % 4)) != 1);
        end
    endtask

    task automatic square_run(input string tag, input logic [7:0] ctl, input logic [7:0] lo,
                              input int n, input int ticks);
        put(1, ctl); put(0, lo); put(0, 8'h00); tick1;
        out_is({tag, " start high"}, 1'b1);
        for (int k = 1; k <= ticks; k++) begin
            tick1;
            out_is($sformatf("%s tick %0d", tag, k), (n - (k % n)) > (n / 2));
        end
    endtask

    task automatic t_square;
        square_run("R9 even", 8'h76, 8'h04, 4, 8);
        square_run("R9 odd", 8'h76, 8'h05, 5, 10);
        square_run("R10 decimal square", 8'h77, 8'h10, 10, 10);
    endtask

    task automatic t_bcd_zero;
        logic [15:0] v;
        put(1, 8'h71); put(0, 8'h10); put(0, 8'h00); tick1; tick1;
        rd_pair(v); chk("R10 decimal borrow", v, 16'h0009);
        put(1, 8'h70); put(0, 8'h00); put(0, 8'h00); tick1; tick1;
        rd_pair(v); chk("R11 binary zero load", v, 16'hFFFF);
        put(1, 8'h71); put(0, 8'h00); put(0, 8'h00); tick1; tick1;
        rd_pair(v); chk("R11 decimal zero load", v, 16'h9999);
    endtask

    task automatic t_latch;
        logic [7:0] b;
        put(1, 8'h70); put(0, 8'h00); put(0, 8'h01); tick1;
        tick1; tick1; tick1;
        put(1, 8'h40);
        tick1; tick1;
        put(1, 8'h40);
        rd_byte(b); chk("R12 latched low byte", {8'h00, b}, 16'h00FD);
        tick1;
        rd_byte(b); chk("R12 latched high byte", {8'h00, b}, 16'h0000);
        rd_byte(b); chk("R12 live low after release", {8'h00, b}, 16'h00FA);
        rd_byte(b); chk("R12 live high after release", {8'h00, b}, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_term;
        t_select;
        t_order;
        t_gate;
        t_rate;
        t_square;
        t_bcd_zero;
        t_latch;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule